// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits beside the program counter logic of a small core and runs one level of hardware repeat. When the decoder reports that a repeat instruction is executing, the block takes a snapshot of three values. The first is the loop start, which is the repeat address plus two, because one instruction slot follows the repeat before the body. The second is the end address, the address of the last body instruction, which the decoder has already fetched from memory. The third is an iteration count, which the core supplies as the number of passes minus one.

After the snapshot, the block compares every fetch address with the stored end address. When the two match and passes remain, it overrides the next fetch with the start address in the same cycle. The decrement, the test and the jump back therefore add no cycles to straight-line code. When the count is exhausted at the end address, the block releases the loop and fetch falls through to the following address. A stalled fetch is ignored, so each completed end-address fetch is counted once. A new repeat strobe always replaces the current context, because there is never more than one loop.

Top module: `hwl_loop_ctrl`

## Requirements
- R1: After reset, loop_active and redirect_valid are both 0.
- R2: In the cycle after a clock edge that sampled rpt_fire high, loop_active is 1.
- R3: While the loop is active, fetch_pc equals the captured end address, stall is 0 and passes remain, redirect_valid is 1 in that same cycle and redirect_pc equals the captured repeat address plus 2.
- R4: A captured count of C makes the body run C+1 times: the end address causes exactly C redirects, and then one fall-through.
- R5: A captured count of 0 runs the body exactly once, with no redirect.
- R6: After the clock edge of the final end-address fetch, loop_active is 0 and redirect_valid stays 0.
- R7: While stall is 1, redirect_valid is 0, and a stalled end-address fetch does not use up a pass.
- R8: Changes to rpt_count and rpt_end after the strobe have no effect on how many passes run or where the body ends.
- R9: While fetch_pc differs from the captured end address, redirect_valid is 0.
- R10: A strobe while a loop is active replaces the whole context, including start, end and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rpt_fire | input | 1 | The repeat instruction executes this cycle |
| rpt_pc | input | ADDR_W | Address of the repeat instruction |
| rpt_count | input | CNT_W | Number of passes minus one |
| rpt_end | input | ADDR_W | Address of the last body instruction |
| fetch_pc | input | ADDR_W | Address being fetched this cycle |
| stall | input | 1 | The fetch does not complete this cycle |
| redirect_pc | output | ADDR_W | Next fetch address when redirect_valid is 1 |
| redirect_valid | output | 1 | Override the next fetch address |
| loop_active | output | 1 | A loop context is live |

## Verification
The case that is hardest to reach from the ports is a stall that lands exactly on the end address, combined with a source operand that changes during the body. A stall there must not consume a pass, and the changed operand must have no effect. Neither fault shows up until a later pass, when the redirect count comes out wrong. The stimulus walks the fetch address through the body the way straight-line fetch would. It holds stall across a clock edge on the first end-address hit, scrambles rpt_count and rpt_end after the strobe, and counts the redirects against the captured count over a sweep of counts and body lengths.

// File: rtl/hwl_pkg.sv
package hwl_pkg;

    // Distance from the repeat instruction to the first body instruction.
    localparam int unsigned SLOT_GAP = 2;

    typedef enum logic {
        LOOP_IDLE = 1'b0,
        LOOP_RUN  = 1'b1
    } loop_state_e;

    function automatic logic [31:0] body_start(input logic [31:0] rpt_addr);
        return rpt_addr + SLOT_GAP;
    endfunction

endpackage

// File: rtl/hwl_ctx.sv
module hwl_ctx
    import hwl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_pc,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic [ADDR_W-1:0] load_end,
    input  logic              pass_done,
    input  logic              last_pass,
    output loop_state_e       state,
    output logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] end_addr,
    output logic [CNT_W-1:0]  remaining
);

    typedef struct packed {
        loop_state_e       st;
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] fin;
        logic [CNT_W-1:0]  cnt;
    } ctx_t;

    ctx_t cur_q, nxt;
    logic [31:0] start_wide;

    always_comb begin
        start_wide = body_start(32'(load_pc));
        nxt = cur_q;
        if (load) begin
            nxt.st    = LOOP_RUN;
            nxt.start = start_wide[ADDR_W-1:0];
            nxt.fin   = load_end;
            nxt.cnt   = load_cnt;
        end else if (pass_done) begin
            if (last_pass) nxt.st  = LOOP_IDLE;
            else           nxt.cnt = cur_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{st: LOOP_IDLE, start: '0, fin: '0, cnt: '0};
        end else begin
            cur_q <= nxt;
        end
    end

    assign state      = cur_q.st;
    assign start_addr = cur_q.start;
    assign end_addr   = cur_q.fin;
    assign remaining  = cur_q.cnt;

endmodule

// File: rtl/hwl_match.sv
module hwl_match
    import hwl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 16
) (
    input  loop_state_e       state,
    input  logic              fire,
    input  logic              stall,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic [ADDR_W-1:0] end_addr,
    input  logic [CNT_W-1:0]  remaining,
    output logic              pass_done,
    output logic              last_pass
);

    assign pass_done = (state == LOOP_RUN) && !stall && !fire && (fetch_pc == end_addr);
    assign last_pass = (remaining == '0);

endmodule

// File: rtl/hwl_loop_ctrl.sv
module hwl_loop_ctrl
    import hwl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rpt_fire,
    input  logic [ADDR_W-1:0] rpt_pc,
    input  logic [CNT_W-1:0]  rpt_count,
    input  logic [ADDR_W-1:0] rpt_end,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              stall,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic              redirect_valid,
    output logic              loop_active
);

    loop_state_e       ctx_state;
    logic [ADDR_W-1:0] ctx_start;
    logic [ADDR_W-1:0] ctx_end;
    logic [CNT_W-1:0]  ctx_cnt;
    logic              pass_done;
    logic              last_pass;

    hwl_ctx #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctx (
        .clk        (clk),
        .rst        (rst),
        .load       (rpt_fire),
        .load_pc    (rpt_pc),
        .load_cnt   (rpt_count),
        .load_end   (rpt_end),
        .pass_done  (pass_done),
        .last_pass  (last_pass),
        .state      (ctx_state),
        .start_addr (ctx_start),
        .end_addr   (ctx_end),
        .remaining  (ctx_cnt)
    );

    hwl_match #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_match (
        .state     (ctx_state),
        .fire      (rpt_fire),
        .stall     (stall),
        .fetch_pc  (fetch_pc),
        .end_addr  (ctx_end),
        .remaining (ctx_cnt),
        .pass_done (pass_done),
        .last_pass (last_pass)
    );

    assign redirect_valid = pass_done && !last_pass;
    assign redirect_pc    = ctx_start;
    assign loop_active    = (ctx_state == LOOP_RUN);

endmodule

// File: rtl/hwl_loop_ctrl_chk.sv
module hwl_loop_ctrl_chk #(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              rpt_fire,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              stall,
    input logic [ADDR_W-1:0] redirect_pc,
    input logic              redirect_valid,
    input logic              loop_active,
    input logic [ADDR_W-1:0] ctx_start,
    input logic [ADDR_W-1:0] ctx_end,
    input logic [CNT_W-1:0]  ctx_cnt
);

    p_fire_arms_r2: assert property (@(posedge clk) disable iff (rst)
        rpt_fire |=> loop_active);

    p_redirect_needs_active_r3: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> (loop_active && redirect_pc == ctx_start));

    p_redirect_at_end_r9: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> (fetch_pc == ctx_end));

    p_stall_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        stall |-> !redirect_valid);

    p_stall_holds_count_r7: assert property (@(posedge clk) disable iff (rst)
        (stall && !rpt_fire) |=> $stable(ctx_cnt));

    p_redirect_stays_active_r4: assert property (@(posedge clk) disable iff (rst)
        (redirect_valid && !rpt_fire) |=> loop_active);

    p_final_pass_releases_r6: assert property (@(posedge clk) disable iff (rst)
        (loop_active && !stall && !rpt_fire && fetch_pc == ctx_end && ctx_cnt == '0)
        |=> !loop_active);

endmodule

bind hwl_loop_ctrl hwl_loop_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .rpt_fire       (rpt_fire),
    .fetch_pc       (fetch_pc),
    .stall          (stall),
    .redirect_pc    (redirect_pc),
    .redirect_valid (redirect_valid),
    .loop_active    (loop_active),
    .ctx_start      (ctx_start),
    .ctx_end        (ctx_end),
    .ctx_cnt        (ctx_cnt)
);

// File: tb/hwl_loop_ctrl_bench.sv
module hwl_loop_ctrl_bench;
    localparam int ADDR_W = 12;
    localparam int CNT_W  = 16;
    localparam time CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst;
    logic              rpt_fire;
    logic [ADDR_W-1:0] rpt_pc;
    logic [CNT_W-1:0]  rpt_count;
    logic [ADDR_W-1:0] rpt_end;
    logic [ADDR_W-1:0] fetch_pc;
    logic              stall;
    logic [ADDR_W-1:0] redirect_pc;
    logic              redirect_valid;
    logic              loop_active;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hwl_loop_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_hwl_loop_ctrl (
        .clk(clk), .rst(rst), .rpt_fire(rpt_fire), .rpt_pc(rpt_pc),
        .rpt_count(rpt_count), .rpt_end(rpt_end), .fetch_pc(fetch_pc),
        .stall(stall), .redirect_pc(redirect_pc),
        .redirect_valid(redirect_valid), .loop_active(loop_active)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=0 cycles left", cycles);
            report();
        end
    end

    // Drives one repeat and walks fetch through the body, counting redirects.
    task automatic run_loop(input int base, input int cnt, input int len,
                            input bit do_stall, input bit scramble);
        int e = base + 2 + len - 1;
        int pc = base + 2;
        int rem = cnt;
        int redirs = 0;
        bit stalled = 1'b0;
        bit fin = 1'b0;
        @(negedge clk);
        rpt_fire = 1'b1; rpt_pc = ADDR_W'(base); rpt_count = CNT_W'(cnt);
        rpt_end = ADDR_W'(e); fetch_pc = ADDR_W'(base); stall = 1'b0;
        @(negedge clk);
        rpt_fire = 1'b0;
        if (scramble) begin
            rpt_count = CNT_W'(cnt + 7);   // R8: ignored after capture
            rpt_end   = ADDR_W'(e + 1);
        end
        fetch_pc = ADDR_W'(base + 1);
        #1;
        check("R2 active after strobe", int'(loop_active), 1);
        check("R9 slot no redirect", int'(redirect_valid), 0);
        while (!fin) begin
            @(negedge clk);
            fetch_pc = ADDR_W'(pc);
            stall = 1'b0;
            #1;
            if (pc == e) begin
                if (do_stall && !stalled) begin
                    stalled = 1'b1;
                    stall = 1'b1;
                    #1;
                    check("R7 stall blocks redirect", int'(redirect_valid), 0);
                    @(negedge clk);
                    stall = 1'b0;
                    #1;
                end
                check("R3 R4 R5 redirect at end", int'(redirect_valid), int'(rem != 0));
                if (rem != 0) begin
                    check("R3 redirect target", int'(redirect_pc), base + 2);
                    rem--;
                    redirs++;
                    pc = base + 2;
                end else begin
                    fin = 1'b1;
                end
            end else begin
                check("R9 body no redirect", int'(redirect_valid), 0);
                pc++;
            end
        end
        @(negedge clk);
        fetch_pc = ADDR_W'(e + 1);
        #1;
        check("R6 released", int'(loop_active), 0);
        check("R6 no redirect", int'(redirect_valid), 0);
        check("R4 R5 R8 redirect count", redirs, cnt);
    endtask

    initial begin
        rst = 1'b1; rpt_fire = 1'b0; rpt_pc = '0; rpt_count = '0;
        rpt_end = '0; fetch_pc = '0; stall = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 loop_active reset", int'(loop_active), 0);
        check("R1 redirect_valid reset", int'(redirect_valid), 0);

        // Sweep counts and body lengths, with and without stall and scrambling.
        for (int c = 0; c < 6; c++) begin
            for (int l = 1; l < 4; l++) begin
                run_loop(16 + 8*l, c, l, 1'b0, 1'b0);
                run_loop(200 + 4*c, c, l, 1'b1, 1'b1);
            end
        end

        // R10: restart while a loop runs.
        @(negedge clk);
        rpt_fire = 1'b1; rpt_pc = 12'd100; rpt_count = 16'd5; rpt_end = 12'd103;
        @(negedge clk);
        rpt_fire = 1'b0; fetch_pc = 12'd102;
        @(negedge clk);
        fetch_pc = 12'd103;
        #1;
        check("R10 first loop redirects", int'(redirect_valid), 1);
        @(negedge clk);
        fetch_pc = 12'd102;
        run_loop(300, 0, 2, 1'b0, 1'b0);
        @(negedge clk);
        fetch_pc = 12'd103;
        #1;
        check("R10 old end ignored", int'(redirect_valid), 0);

        done = 1'b1;
        report();
    end
endmodule